// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a 32-bit interval timer that counts down on the system clock and is driven through a small word-addressed register bus. Software loads a period as two 16-bit halves. It starts the timer with a strobe bit and can stop it the same way. Each interval lasts the period plus one clock cycles. At the end of each interval the timer raises a sticky timeout flag. In one-shot mode it then halts. In continuous mode it reloads and keeps counting.

The live count is not readable directly. A write to either snapshot address latches the whole count into a pair of 16-bit snapshot registers, which software then reads. A level interrupt output is high while the timeout flag is set and interrupts are enabled. Register reads are combinational from the address. Every register update happens on the clock edge that samples the write.

Register map, word offsets. The offsets are the decode the bus relies on:

- 0, status: bit 0 is timeout, bit 1 is running. A write of any value clears timeout.
- 1, control: bit 0 is interrupt enable, bit 1 is continuous, bit 2 is the start strobe, bit 3 is the stop strobe.
- 2 and 3: period low half and period high half.
- 4 and 5: snapshot low half and snapshot high half.

Top module: `ivl_timer`

## Requirements
- R1: After reset every readable register (offsets 0 to 5) reads zero, the timer is stopped, irq is low, and the counter holds all ones, so a snapshot taken right after reset reads 0xFFFF in both halves.
- R2: Control stores only bit 0 (interrupt enable) and bit 1 (continuous). A control read returns those two bits, and bits 2 and 3 always read as zero.
- R3: A control write with bit 2 set starts a stopped timer. While the timer is running it has no effect and does not restart the count. A control write with bit 3 set halts the timer. When both bits are set in one write the timer ends up halted. A halted timer keeps its count.
- R4: A write to offset 2 or 3 stores bits 15:0 of the data into that half of the period. It halts the timer and loads the counter with the combined period {high, low}.
- R5: While the timer is running, the count drops by one on every clock from the period down to zero. The timeout flag (status bit 0) is set on the clock edge that follows the clock on which the count is zero. That makes period plus one clocks per interval.
- R6: At expiry in one-shot mode (control bit 1 clear), the timeout flag sets, the running flag (status bit 1) clears and the counter is left holding the period.
- R7: At expiry in continuous mode (control bit 1 set), the counter reloads the period and keeps running, so the timer expires every period plus one clocks.
- R8: A write of any data to offset 0 clears the timeout flag. If expiry happens in the same cycle, the flag stays set.
- R9: A write to offset 4 or 5 captures the count as it stood before that clock edge. Bits 15:0 go to offset 4 and bits 31:16 go to offset 5.
- R10: irq is high exactly when the timeout flag and control bit 0 are both set.
- R11: Offsets 6 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the counter advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register, one write per cycle |
| bus_addr | input | 3 | Word offset of the register being read or written |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| irq | output | 1 | Level interrupt: timeout flag AND interrupt enable |

## Verification
The assertions assume that a write on the bus lasts exactly one cycle, that the address is held steady while the write strobe is high, and that a period write never coincides with a start strobe. That last point holds because the two sit at different offsets. The bench drives every write for exactly one clock between falling edges and keeps the strobe low otherwise. It reads only combinationally between edges, so no read can disturb the state. Scenarios that cross on purpose, such as a status write on the expiry edge or start and stop strobes in the same write, are timed to the exact edge from the period value the bench itself loaded.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

    localparam int ADDR_W = 3;

    // Word offsets; the bus decode depends on these values.
    typedef enum logic [ADDR_W-1:0] {
        RS_STATUS  = 3'd0,
        RS_CTRL    = 3'd1,
        RS_PER_LO  = 3'd2,
        RS_PER_HI  = 3'd3,
        RS_SNAP_LO = 3'd4,
        RS_SNAP_HI = 3'd5
    } reg_sel_e;

    // Bit positions within status and control.
    localparam int ST_TIMEOUT = 0;
    localparam int ST_RUN     = 1;
    localparam int CT_IE      = 0;
    localparam int CT_CONT    = 1;
    localparam int CT_START   = 2;
    localparam int CT_STOP    = 3;

    typedef struct packed {
        logic ie;
        logic cont;
    } ctrl_t;

    // One-cycle commands from the register file to the counter.
    typedef struct packed {
        logic start;
        logic stop;
        logic load;
    } tmr_cmd_t;

    function automatic logic is_snap(input logic [ADDR_W-1:0] a);
        return (a == RS_SNAP_LO) || (a == RS_SNAP_HI);
    endfunction

endpackage

// File: rtl/ivl_timer_core.sv
module ivl_timer_core
    import ivl_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_cmd_t         cmd,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    input  logic             cont,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assign expire = running && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '1;
            running <= 1'b0;
        end else begin
            if (cmd.load)
                cnt <= load_val;
            else if (expire)
                cnt <= period;
            else if (running)
                cnt <= cnt - ONE;

            if (cmd.load || cmd.stop)
                running <= 1'b0;
            else if (expire && !cont)
                running <= 1'b0;
            else if (cmd.start)
                running <= 1'b1;
        end
    end

    a_r5_countdown: assert property (@(posedge clk) disable iff (rst)
        (running && !expire && !cmd.load) |=> (cnt == $past(cnt) - ONE));

    a_r6_oneshot_halt: assert property (@(posedge clk) disable iff (rst)
        (expire && !cont && !cmd.load) |=> (!running && cnt == $past(period)));

    a_r7_cont_reload: assert property (@(posedge clk) disable iff (rst)
        (expire && cont && !cmd.load && !cmd.stop) |=> (running && cnt == $past(period)));

    a_r4_load_halts: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (!running && cnt == $past(load_val)));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!running && !cmd.load) |=> $stable(cnt));

    a_r3_stop_wins: assert property (@(posedge clk) disable iff (rst)
        cmd.stop |=> !running);

    a_r3_start: assert property (@(posedge clk) disable iff (rst)
        (cmd.start && !cmd.stop && !cmd.load && !running) |=> running);

endmodule

// File: rtl/ivl_timer_regs.sv
module ivl_timer_regs
    import ivl_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              running,
    input  logic              expire,
    output logic [CNT_W-1:0]  bus_rdata,
    output tmr_cmd_t          cmd,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  period,
    output logic              cont,
    output logic              irq
);

    localparam int HALF_W = CNT_W / 2;

    ctrl_t             ctrl_q;
    logic              timeout_q;
    logic [CNT_W-1:0]  snap_all;
    logic              wr_status, wr_ctrl, wr_snap;
    logic [1:0]        wr_per;
    logic              unused_hi;

    assign unused_hi = ^bus_wdata[CNT_W-1:HALF_W];

    always_comb begin
        wr_status = bus_wr && (bus_addr == RS_STATUS);
        wr_ctrl   = bus_wr && (bus_addr == RS_CTRL);
        wr_snap   = bus_wr && is_snap(bus_addr);
        wr_per[0] = bus_wr && (bus_addr == RS_PER_LO);
        wr_per[1] = bus_wr && (bus_addr == RS_PER_HI);
        cmd.start = wr_ctrl && bus_wdata[CT_START];
        cmd.stop  = wr_ctrl && bus_wdata[CT_STOP];
        cmd.load  = |wr_per;
    end

    // Period and snapshot halves: index 0 is the low half.
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF_W-1:0] per_r;
        logic [HALF_W-1:0] snap_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                per_r  <= '0;
                snap_r <= '0;
            end else begin
                if (wr_per[h])
                    per_r <= bus_wdata[HALF_W-1:0];
                if (wr_snap)
                    snap_r <= cnt[h*HALF_W +: HALF_W];
            end
        end

        assign period[h*HALF_W +: HALF_W]   = per_r;
        assign load_val[h*HALF_W +: HALF_W] = wr_per[h] ? bus_wdata[HALF_W-1:0] : per_r;
        assign snap_all[h*HALF_W +: HALF_W] = snap_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            timeout_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.ie   <= bus_wdata[CT_IE];
                ctrl_q.cont <= bus_wdata[CT_CONT];
            end
            if (expire)
                timeout_q <= 1'b1;
            else if (wr_status)
                timeout_q <= 1'b0;
        end
    end

    assign cont = ctrl_q.cont;
    assign irq  = timeout_q && ctrl_q.ie;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RS_STATUS: begin
                bus_rdata[ST_TIMEOUT] = timeout_q;
                bus_rdata[ST_RUN]     = running;
            end
            RS_CTRL: begin
                bus_rdata[CT_IE]   = ctrl_q.ie;
                bus_rdata[CT_CONT] = ctrl_q.cont;
            end
            RS_PER_LO:  bus_rdata[HALF_W-1:0] = period[HALF_W-1:0];
            RS_PER_HI:  bus_rdata[HALF_W-1:0] = period[CNT_W-1:HALF_W];
            RS_SNAP_LO: bus_rdata[HALF_W-1:0] = snap_all[HALF_W-1:0];
            RS_SNAP_HI: bus_rdata[HALF_W-1:0] = snap_all[CNT_W-1:HALF_W];
            default:    bus_rdata = '0;
        endcase
    end

    a_r8_status_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_status && !expire) |=> !timeout_q);

    a_r6_timeout_set: assert property (@(posedge clk) disable iff (rst)
        expire |=> timeout_q);

    a_r9_snap_capture: assert property (@(posedge clk) disable iff (rst)
        wr_snap |=> (snap_all == $past(cnt)));

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    tmr_cmd_t         cmd;
    logic [CNT_W-1:0] load_val, period, cnt;
    logic             cont, running, expire;

    ivl_timer_regs #(.CNT_W(CNT_W)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt       (cnt),
        .running   (running),
        .expire    (expire),
        .bus_rdata (bus_rdata),
        .cmd       (cmd),
        .load_val  (load_val),
        .period    (period),
        .cont      (cont),
        .irq       (irq)
    );

    ivl_timer_core #(.CNT_W(CNT_W)) i_core (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_val (load_val),
        .period   (period),
        .cont     (cont),
        .cnt      (cnt),
        .running  (running),
        .expire   (expire)
    );

endmodule

// File: tb/test_ivl_timer.sv
`timescale 1ns/100ps
module test_ivl_timer;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr = 1'b0;
    logic [2:0]   addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         irq;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    ivl_timer #(.CNT_W(W)) i_ivl_timer (
        .clk(clk), .rst(rst), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #0.1;
        check(req, rdata, exp);
        addr = '0;
    endtask

    task automatic chk_irq(input string req, input logic exp);
        #0.1;
        check(req, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic t_reset();
        for (int a = 0; a < 6; a++) chk_reg("R1 reg zero", a[2:0], 32'h0);
        chk_irq("R1 irq low", 1'b0);
        wr_reg(3'd4, 32'h0);
        chk_reg("R1 counter all ones lo", 3'd4, 32'h0000_FFFF);
        chk_reg("R1 counter all ones hi", 3'd5, 32'h0000_FFFF);
    endtask

    task automatic t_ctrl();
        wr_reg(3'd1, 32'hFFFF_FFFB);
        chk_reg("R2 ctrl readback", 3'd1, 32'h3);
        chk_reg("R3 stop keeps halted", 3'd0, 32'h0);
        wr_reg(3'd1, 32'h0);
        chk_reg("R2 ctrl cleared", 3'd1, 32'h0);
    endtask

    task automatic t_period();
        wr_reg(3'd2, 32'hABCD_1234);
        chk_reg("R4 period lo 16 bits", 3'd2, 32'h0000_1234);
        wr_reg(3'd3, 32'h5555_0001);
        chk_reg("R4 period hi 16 bits", 3'd3, 32'h0000_0001);
        wr_reg(3'd5, 32'h0);
        chk_reg("R4 R9 reload lo", 3'd4, 32'h0000_1234);
        chk_reg("R4 R9 reload hi", 3'd5, 32'h0000_0001);
    endtask

    task automatic t_oneshot();
        wr_reg(3'd2, 32'd5);
        wr_reg(3'd3, 32'd0);
        wr_reg(3'd1, 32'h5);          // ie + start, edge E0
        wr_reg(3'd4, 32'h0);          // snapshot at E1
        chk_reg("R9 snap at first tick", 3'd4, 32'd5);
        chk_reg("R3 started", 3'd0, 32'h2);
        idle(4);                      // after E5
        chk_reg("R5 no timeout before period+1", 3'd0, 32'h2);
        chk_irq("R10 irq low before expiry", 1'b0);
        idle(1);                      // after E6
        chk_reg("R6 oneshot halts with timeout", 3'd0, 32'h1);
        chk_irq("R10 irq with enable", 1'b1);
        wr_reg(3'd5, 32'h0);
        chk_reg("R6 holds period lo", 3'd4, 32'd5);
        chk_reg("R6 holds period hi", 3'd5, 32'd0);
        wr_reg(3'd0, 32'h0);
        chk_reg("R8 status write clears", 3'd0, 32'h0);
        chk_irq("R10 irq drops", 1'b0);
    endtask

    task automatic t_cont();
        wr_reg(3'd2, 32'd3);
        wr_reg(3'd1, 32'h6);          // cont + start, E0
        idle(3);                      // after E3
        chk_reg("R7 running before expiry", 3'd0, 32'h2);
        wr_reg(3'd0, 32'hFFFF_FFFF);  // E4 = expiry edge
        chk_reg("R8 expiry beats clear", 3'd0, 32'h3);
        wr_reg(3'd0, 32'h0);          // E5
        chk_reg("R8 clear, R7 still running", 3'd0, 32'h2);
        idle(2);                      // after E7
        chk_reg("R7 no early second expiry", 3'd0, 32'h2);
        idle(1);                      // after E8
        chk_reg("R7 second expiry", 3'd0, 32'h3);
        chk_irq("R10 masked irq", 1'b0);
        wr_reg(3'd1, 32'h3);          // E9
        chk_irq("R10 enable raises irq", 1'b1);
        wr_reg(3'd1, 32'h8);          // E10 stop, count 1 after edge
        chk_reg("R3 stop halts", 3'd0, 32'h1);
        chk_irq("R10 enable cleared", 1'b0);
        wr_reg(3'd4, 32'h0);
        chk_reg("R3 halted count", 3'd4, 32'd1);
        idle(3);
        wr_reg(3'd4, 32'h0);
        chk_reg("R3 count held", 3'd4, 32'd1);
    endtask

    task automatic t_strobes();
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd1, 32'hC);
        chk_reg("R3 start+stop halted", 3'd0, 32'h0);
        wr_reg(3'd1, 32'h4);
        chk_reg("R3 start", 3'd0, 32'h2);
        wr_reg(3'd3, 32'hFFFF_0002);
        chk_reg("R4 period write halts", 3'd0, 32'h0);
        wr_reg(3'd1, 32'h4);          // E0, count 0x20003
        wr_reg(3'd4, 32'h0);          // E1 captures 0x20003
        chk_reg("R9 snap lo", 3'd4, 32'h3);
        chk_reg("R9 snap hi", 3'd5, 32'h2);
        wr_reg(3'd1, 32'h4);          // E2 restart attempt
        wr_reg(3'd5, 32'h0);          // E3 captures 0x20001
        chk_reg("R3 restart ignored lo", 3'd4, 32'h1);
        chk_reg("R3 restart ignored hi", 3'd5, 32'h2);
        wr_reg(3'd1, 32'h8);
    endtask

    task automatic t_unmapped();
        wr_reg(3'd6, 32'hFFFF_FFFF);
        wr_reg(3'd7, 32'hFFFF_FFFF);
        chk_reg("R11 offset 6 zero", 3'd6, 32'h0);
        chk_reg("R11 offset 7 zero", 3'd7, 32'h0);
        chk_reg("R11 ctrl untouched", 3'd1, 32'h0);
        chk_reg("R11 status untouched", 3'd0, 32'h0);
        chk_reg("R11 period lo untouched", 3'd2, 32'h3);
        chk_reg("R11 period hi untouched", 3'd3, 32'h2);
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl();
        t_period();
        t_oneshot();
        t_cont();
        t_strobes();
        t_unmapped();
        finish_sim();
    end

    initial begin
        #200000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        finish_sim();
    end

endmodule